// File: doc/BRIEF.md
# Multiplexed LED Digit Scanner with Two-Plane Blinking

This block drives a common-cathode LED display by time-multiplexing: it lights one digit slot at a time, with one select line per slot and a shared bus of segment enables. Each slot holds two stored data bytes, one in plane A (P0) and one in plane B (P1). A divided blink clock alternates between the two planes when blinking is enabled. Each bit of a data byte drives one segment line directly, and a character decoder can be placed in front of the write port. The width of each digit's lit window comes from a 4-bit brightness code. The code is either one shared value or a separate value per digit.

Each slot period has 16 steps of `STEP_CYC` clocks. Step 0 is always dark, and this is the only point where the select and segment outputs change. The lit window starts at step 1 and lasts for the number of steps set by the brightness code, and the slot stays dark for the rest of its steps. A control state machine has four states. `SCAN_OFF` is the shutdown state: all outputs are off and the timers hold. `SCAN_GAP` is the dark step 0. `SCAN_LIT` is the lit window. `SCAN_DARK` is the unlit rest of the slot. The transitions are:
- OFF→GAP when shutdown is cleared.
- GAP→LIT at the end of step 0. The slot's segment pattern and width are latched here.
- LIT→DARK at the end of the last lit step.
- LIT→GAP or DARK→GAP at the end of step 15, which also advances the slot.
- Any state→OFF while shutdown is set.

Top module: `led_mux_scanner`

## Requirements
- R1: After reset, `dig_sel`, `seg_on` and `blink_phase` are all 0. Shutdown is set, both planes and all brightness nibbles are 0, and the scan limit is 0. The display stays dark until a configuration write clears shutdown.
- R2: A scan limit L selects slots 0 to L. These slots are lit in ascending order, and after slot L the scan wraps to slot 0. No slot above L is ever selected.
- R3: A slot lasts 16×`STEP_CYC` clocks. For a brightness code c, the lit window is min(c+1,15)×`STEP_CYC` consecutive clocks, so the duty runs from 1/16 to 15/16. The dark time from the end of one window to the start of the next is (16−min(c+1,15))×`STEP_CYC` clocks, and is never less than one step.
- R4: When `cfg_per_digit` is 0, every slot uses `cfg_glob_int`. When it is 1, each slot uses its own stored nibble. A write of `int_byte` to pair p stores bits [3:0] for slot 2p and bits [7:4] for slot 2p+1.
- R5: During a lit window, bit i of `seg_on` equals bit i of the displayed data byte of the selected slot. With blinking disabled, the displayed byte is always the plane A byte.
- R6: With blinking enabled, a lit window shows plane A when `blink_phase` is 0 and plane B when it is 1. The plane is chosen when the window starts.
- R7: `blink_phase` toggles every `SLOW_HALF_CYC` clocks when `cfg_blink_fast` is 0, and every `FAST_HALF_CYC` clocks when it is 1. It runs whether or not blinking is enabled, and it holds only in shutdown.
- R8: A configuration write with `cfg_restart` set forces `blink_phase` to 0 and restarts the half-period count. The next toggle comes exactly one half period later. The bit is not stored.
- R9: A configuration write with `cfg_clear` set zeroes every slot in both planes. The bit is not stored.
- R10: In test mode, every lit window drives all segments on and lasts 15 steps, whatever the data or brightness code.
- R11: In shutdown, `dig_sel` and `seg_on` are 0 and `blink_phase` holds its value. The stored data is kept. When shutdown is cleared, the scan restarts at slot 0 and shows the retained data.
- R12: `dig_sel` has at most one bit set, and `seg_on` is 0 whenever no slot is selected. Both outputs stay constant for the whole of a lit window.
- R13: A write to the data port stores `wr_data` for slot `wr_slot` into plane A when `wr_p0` is set, and into plane B when `wr_p1` is set, or into both planes when both bits are set. The other plane is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplex clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_shutdown | input | 1 | Shutdown (1 = outputs off) |
| cfg_blink_en | input | 1 | Enable plane alternation |
| cfg_blink_fast | input | 1 | Blink rate select (1 = fast) |
| cfg_per_digit | input | 1 | Brightness source (1 = per-digit nibbles) |
| cfg_test | input | 1 | Test mode: all segments on, full width |
| cfg_restart | input | 1 | Transient: restart the blink timer |
| cfg_clear | input | 1 | Transient: clear both planes |
| cfg_scan_limit | input | clog2(NUM_SLOTS) | Highest slot index that is scanned |
| cfg_glob_int | input | 4 | Shared brightness code |
| wr_en | input | 1 | Digit data write strobe |
| wr_p0 | input | 1 | Write targets plane A |
| wr_p1 | input | 1 | Write targets plane B |
| wr_slot | input | clog2(NUM_SLOTS) | Slot index for the data write |
| wr_data | input | SEG_W | Segment data byte |
| int_wr | input | 1 | Brightness pair write strobe |
| int_pair | input | clog2(NUM_SLOTS/2) | Slot pair index |
| int_byte | input | 8 | Two brightness nibbles (low = even slot) |
| dig_sel | output | NUM_SLOTS | One-hot digit select, active high |
| seg_on | output | SEG_W | Segment enables, active high |
| blink_phase | output | 1 | Current blink phase (1 = plane B) |

## Verification
The assertions assume that the configuration, data and brightness inputs change only together with their write strobes. They also assume that the scan limit is not lowered below the current slot in the middle of a window that is being checked. The bench drives every input on the falling edge and pulses each strobe for exactly one clock. It changes the configuration only between measured windows, and it throws away the first window after each change so that every measurement reflects the new settings.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    typedef enum logic [1:0] {
        SCAN_OFF,
        SCAN_GAP,
        SCAN_LIT,
        SCAN_DARK
    } scan_state_t;

    localparam int STEPS_PER_SLOT = 16;
    localparam logic [3:0] LAST_STEP = 4'd15;
    localparam logic [3:0] MAX_ON_STEPS = 4'd15;

    typedef struct packed {
        logic       shutdown;
        logic       blink_en;
        logic       blink_fast;
        logic       per_digit;
        logic       test;
        logic [3:0] glob_int;
    } scan_cfg_t;

    // Lit steps for a brightness code: code+1, capped at 15.
    function automatic logic [3:0] on_steps_f(input logic [3:0] code);
        return (code == 4'hF) ? MAX_ON_STEPS : code + 4'd1;
    endfunction

endpackage

// File: rtl/lm_step_timer.sv
module lm_step_timer #(
    parameter int STEP_CYC = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    output logic       step_end,
    output logic [3:0] step_idx
);
    localparam int TW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(STEP_CYC - 1);

    logic [TW-1:0] tick_q;

    assign step_end = (tick_q == TICK_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            tick_q   <= '0;
            step_idx <= '0;
        end else if (step_end) begin
            tick_q   <= '0;
            step_idx <= step_idx + 4'd1;
        end else begin
            tick_q   <= tick_q + TW'(1);
        end
    end
endmodule

// File: rtl/lm_blink_gen.sv
module lm_blink_gen #(
    parameter int SLOW_HALF_CYC = 2_000_000,
    parameter int FAST_HALF_CYC = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    input  logic restart,
    output logic phase
);
    localparam int CW = $clog2(SLOW_HALF_CYC + 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_HALF_CYC - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_HALF_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = fast ? FAST_LAST : SLOW_LAST;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (run) begin
            if (cnt_q >= last) begin
                cnt_q <= '0;
                phase <= ~phase;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/lm_plane_store.sv
module lm_plane_store #(
    parameter int NUM_SLOTS = 8,
    parameter int SEG_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            wr_en,
    input  logic                            wr_p0,
    input  logic                            wr_p1,
    input  logic [$clog2(NUM_SLOTS)-1:0]    wr_slot,
    input  logic [SEG_W-1:0]                wr_data,
    input  logic                            int_wr,
    input  logic [$clog2(NUM_SLOTS/2)-1:0]  int_pair,
    input  logic [7:0]                      int_byte,
    input  logic [$clog2(NUM_SLOTS)-1:0]    rd_slot,
    output logic [SEG_W-1:0]                rd_p0,
    output logic [SEG_W-1:0]                rd_p1,
    output logic [3:0]                      rd_int
);
    localparam int SW = $clog2(NUM_SLOTS);
    localparam int PW = $clog2(NUM_SLOTS / 2);

    logic [SEG_W-1:0] plane_a [NUM_SLOTS];
    logic [SEG_W-1:0] plane_b [NUM_SLOTS];
    logic [3:0]       bright  [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [SW-1:0] SLOT_ID = SW'(s);
        localparam logic [PW-1:0] PAIR_ID = PW'(s / 2);
        logic hit;
        assign hit = wr_en && (wr_slot == SLOT_ID);

        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                plane_a[s] <= '0;
                plane_b[s] <= '0;
            end else begin
                if (hit && wr_p0) plane_a[s] <= wr_data;
                if (hit && wr_p1) plane_b[s] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bright[s] <= '0;
            end else if (int_wr && (int_pair == PAIR_ID)) begin
                bright[s] <= (s % 2 == 1) ? int_byte[7:4] : int_byte[3:0];
            end
        end
    end

    assign rd_p0  = plane_a[rd_slot];
    assign rd_p1  = plane_b[rd_slot];
    assign rd_int = bright[rd_slot];
endmodule

// File: rtl/led_mux_scanner.sv
module led_mux_scanner
    import led_scan_pkg::*;
#(
    parameter int NUM_SLOTS     = 8,
    parameter int SEG_W         = 8,
    parameter int STEP_CYC      = 50,
    parameter int SLOW_HALF_CYC = 2_000_000,
    parameter int FAST_HALF_CYC = 1_000_000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_wr,
    input  logic                            cfg_shutdown,
    input  logic                            cfg_blink_en,
    input  logic                            cfg_blink_fast,
    input  logic                            cfg_per_digit,
    input  logic                            cfg_test,
    input  logic                            cfg_restart,
    input  logic                            cfg_clear,
    input  logic [$clog2(NUM_SLOTS)-1:0]    cfg_scan_limit,
    input  logic [3:0]                      cfg_glob_int,
    input  logic                            wr_en,
    input  logic                            wr_p0,
    input  logic                            wr_p1,
    input  logic [$clog2(NUM_SLOTS)-1:0]    wr_slot,
    input  logic [SEG_W-1:0]                wr_data,
    input  logic                            int_wr,
    input  logic [$clog2(NUM_SLOTS/2)-1:0]  int_pair,
    input  logic [7:0]                      int_byte,
    output logic [NUM_SLOTS-1:0]            dig_sel,
    output logic [SEG_W-1:0]                seg_on,
    output logic                            blink_phase
);
    localparam int SW = $clog2(NUM_SLOTS);

    scan_cfg_t        cfg_q;
    logic [SW-1:0]    lim_q;
    scan_state_t      state_q, state_d;
    logic [SW-1:0]    slot_q;
    logic [SEG_W-1:0] seg_q;
    logic [3:0]       on_q;

    logic             step_end;
    logic [3:0]       step_idx;
    logic [SEG_W-1:0] rd_p0, rd_p1, pattern;
    logic [3:0]       rd_int, code, steps;
    logic             restart_pulse, clear_pulse, shut_w;

    assign restart_pulse = cfg_wr && cfg_restart;
    assign clear_pulse   = cfg_wr && cfg_clear;
    assign shut_w        = cfg_q.shutdown;

    // Stored configuration; restart and clear are not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.shutdown   <= 1'b1;
            cfg_q.blink_en   <= 1'b0;
            cfg_q.blink_fast <= 1'b0;
            cfg_q.per_digit  <= 1'b0;
            cfg_q.test       <= 1'b0;
            cfg_q.glob_int   <= 4'd0;
            lim_q            <= '0;
        end else if (cfg_wr) begin
            cfg_q.shutdown   <= cfg_shutdown;
            cfg_q.blink_en   <= cfg_blink_en;
            cfg_q.blink_fast <= cfg_blink_fast;
            cfg_q.per_digit  <= cfg_per_digit;
            cfg_q.test       <= cfg_test;
            cfg_q.glob_int   <= cfg_glob_int;
            lim_q            <= cfg_scan_limit;
        end
    end

    lm_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (state_q == SCAN_OFF),
        .step_end (step_end),
        .step_idx (step_idx)
    );

    lm_blink_gen #(
        .SLOW_HALF_CYC (SLOW_HALF_CYC),
        .FAST_HALF_CYC (FAST_HALF_CYC)
    ) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!cfg_q.shutdown),
        .fast    (cfg_q.blink_fast),
        .restart (restart_pulse),
        .phase   (blink_phase)
    );

    lm_plane_store #(.NUM_SLOTS(NUM_SLOTS), .SEG_W(SEG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_pulse),
        .wr_en    (wr_en),
        .wr_p0    (wr_p0),
        .wr_p1    (wr_p1),
        .wr_slot  (wr_slot),
        .wr_data  (wr_data),
        .int_wr   (int_wr),
        .int_pair (int_pair),
        .int_byte (int_byte),
        .rd_slot  (slot_q),
        .rd_p0    (rd_p0),
        .rd_p1    (rd_p1),
        .rd_int   (rd_int)
    );

    // Values latched when a lit window opens.
    assign pattern = cfg_q.test ? {SEG_W{1'b1}}
                   : ((cfg_q.blink_en && blink_phase) ? rd_p1 : rd_p0);
    assign code    = cfg_q.per_digit ? rd_int : cfg_q.glob_int;
    assign steps   = cfg_q.test ? MAX_ON_STEPS : on_steps_f(code);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCAN_OFF;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_OFF:  state_d = SCAN_GAP;
            SCAN_GAP:  if (step_end) state_d = SCAN_LIT;
            SCAN_LIT: begin
                if (step_end) begin
                    if (step_idx == LAST_STEP)  state_d = SCAN_GAP;
                    else if (step_idx == on_q)  state_d = SCAN_DARK;
                end
            end
            SCAN_DARK: if (step_end && step_idx == LAST_STEP) state_d = SCAN_GAP;
            default:   state_d = SCAN_OFF;
        endcase
        if (cfg_q.shutdown) state_d = SCAN_OFF;
    end

    // Slot index and window latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            seg_q  <= '0;
            on_q   <= '0;
        end else if (state_q == SCAN_OFF) begin
            slot_q <= '0;
        end else if (state_d == SCAN_GAP && state_q != SCAN_GAP) begin
            slot_q <= (slot_q >= lim_q) ? '0 : slot_q + SW'(1);
        end else if (state_q == SCAN_GAP && state_d == SCAN_LIT) begin
            seg_q <= pattern;
            on_q  <= steps;
        end
    end

    // Outputs.
    always_comb begin
        dig_sel = '0;
        seg_on  = '0;
        if (state_q == SCAN_LIT) begin
            dig_sel[slot_q] = 1'b1;
            seg_on          = seg_q;
        end
    end
endmodule

// File: rtl/led_mux_scanner_chk.sv
module led_mux_scanner_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int SEG_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wr,
    input logic                 cfg_restart,
    input logic                 shut_q,
    input logic [NUM_SLOTS-1:0] dig_sel,
    input logic [SEG_W-1:0]     seg_on,
    input logic                 blink_phase
);
    p_sel_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_sel));

    p_seg_dark_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_sel == '0) |-> (seg_on == '0));

    p_no_ghost_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_sel != '0 && dig_sel == $past(dig_sel)) |-> $stable(seg_on));

    p_shut_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
        shut_q |=> (dig_sel == '0 && seg_on == '0));

    p_phase_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_q && !(cfg_wr && cfg_restart)) |=> $stable(blink_phase));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_restart) |=> !blink_phase);
endmodule

bind led_mux_scanner led_mux_scanner_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .SEG_W     (SEG_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_restart (cfg_restart),
    .shut_q      (shut_w),
    .dig_sel     (dig_sel),
    .seg_on      (seg_on),
    .blink_phase (blink_phase)
);

// File: tb/test_led_mux_scanner.sv
module test_led_mux_scanner;
    localparam int NS = 8;
    localparam int SEGW = 8;
    localparam int STEP = 2;
    localparam int SLOW = 400;
    localparam int FAST = 200;

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_wr = 0, cfg_shutdown = 0, cfg_blink_en = 0, cfg_blink_fast = 0;
    logic cfg_per_digit = 0, cfg_test = 0, cfg_restart = 0, cfg_clear = 0;
    logic [2:0] cfg_scan_limit = 0;
    logic [3:0] cfg_glob_int = 0;
    logic wr_en = 0, wr_p0 = 0, wr_p1 = 0;
    logic [2:0] wr_slot = 0;
    logic [7:0] wr_data = 0;
    logic int_wr = 0;
    logic [1:0] int_pair = 0;
    logic [7:0] int_byte = 0;
    logic [NS-1:0] dig_sel;
    logic [SEGW-1:0] seg_on;
    logic blink_phase;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    led_mux_scanner #(
        .NUM_SLOTS(NS), .SEG_W(SEGW), .STEP_CYC(STEP),
        .SLOW_HALF_CYC(SLOW), .FAST_HALF_CYC(FAST)
    ) i_led_mux_scanner (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_shutdown(cfg_shutdown),
        .cfg_blink_en(cfg_blink_en), .cfg_blink_fast(cfg_blink_fast),
        .cfg_per_digit(cfg_per_digit), .cfg_test(cfg_test), .cfg_restart(cfg_restart),
        .cfg_clear(cfg_clear), .cfg_scan_limit(cfg_scan_limit), .cfg_glob_int(cfg_glob_int),
        .wr_en(wr_en), .wr_p0(wr_p0), .wr_p1(wr_p1), .wr_slot(wr_slot), .wr_data(wr_data),
        .int_wr(int_wr), .int_pair(int_pair), .int_byte(int_byte),
        .dig_sel(dig_sel), .seg_on(seg_on), .blink_phase(blink_phase)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int on_steps(input int code);
        return (code >= 14) ? 15 : code + 1;
    endfunction

    task automatic do_cfg(input bit shut, input bit blink, input bit fast, input bit per,
                          input bit test, input bit restart, input bit clear,
                          input int lim, input int gint);
        @(negedge clk);
        cfg_wr = 1; cfg_shutdown = shut; cfg_blink_en = blink; cfg_blink_fast = fast;
        cfg_per_digit = per; cfg_test = test; cfg_restart = restart; cfg_clear = clear;
        cfg_scan_limit = 3'(lim); cfg_glob_int = 4'(gint);
        @(negedge clk);
        cfg_wr = 0; cfg_restart = 0; cfg_clear = 0;
    endtask

    task automatic write_digit(input bit a, input bit b, input int slot, input int data);
        @(negedge clk);
        wr_en = 1; wr_p0 = a; wr_p1 = b; wr_slot = 3'(slot); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 0; wr_p0 = 0; wr_p1 = 0;
    endtask

    task automatic write_int(input int pair, input int val);
        @(negedge clk);
        int_wr = 1; int_pair = 2'(pair); int_byte = 8'(val);
        @(negedge clk);
        int_wr = 0;
    endtask

    // Waits for the next lit window; returns slot, length and segments.
    task automatic get_window(output int idx, output int len, output int seg);
        logic [NS-1:0] sel;
        while (dig_sel != 0) @(negedge clk);
        while (dig_sel == 0) @(negedge clk);
        sel = dig_sel;
        seg = int'(seg_on);
        idx = -1;
        for (int i = 0; i < NS; i++) if (sel[i]) idx = i;
        len = 0;
        while (dig_sel == sel) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic get_gap(output int gap);
        gap = 1;
        @(negedge clk);
        while (dig_sel == 0) begin
            gap++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        bit bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (dig_sel != 0 || seg_on != 0 || blink_phase != 0) bad = 1;
        end
        check(!bad, "R1 reset dark", int'(dig_sel), 0);
    endtask

    task automatic t_scan_limit;
        int idx, len, seg, prev;
        for (int k = 0; k < NS; k++) write_digit(1, 0, k, 8'h10 + k);
        do_cfg(0, 0, 0, 0, 0, 0, 0, 2, 3);
        get_window(idx, len, seg);
        check(idx == 0, "R11 scan starts at slot 0", idx, 0);
        check(seg == 8'h10, "R5 segments from plane A", seg, 8'h10);
        prev = idx;
        for (int n = 0; n < 8; n++) begin
            get_window(idx, len, seg);
            check(idx == (prev + 1) % 3, "R2 scan order and limit", idx, (prev + 1) % 3);
            check(seg == 8'h10 + idx, "R5 segment data", seg, 8'h10 + idx);
            prev = idx;
        end
    endtask

    task automatic t_global_intensity;
        int idx, len, seg, gap;
        int codes[4] = '{0, 7, 14, 15};
        foreach (codes[c]) begin
            do_cfg(0, 0, 0, 0, 0, 0, 0, 7, codes[c]);
            get_window(idx, len, seg);
            get_window(idx, len, seg);
            get_gap(gap);
            check(len == on_steps(codes[c]) * STEP, "R3 lit width", len, on_steps(codes[c]) * STEP);
            check(gap == (16 - on_steps(codes[c])) * STEP, "R3 dark gap", gap,
                  (16 - on_steps(codes[c])) * STEP);
        end
    endtask

    task automatic t_per_digit;
        int idx, len, seg;
        int nib[4] = '{2, 5, 15, 0};
        write_int(0, 8'h52);
        write_int(1, 8'h0F);
        do_cfg(0, 0, 0, 1, 0, 0, 0, 3, 9);
        get_window(idx, len, seg);
        for (int n = 0; n < 6; n++) begin
            get_window(idx, len, seg);
            check(len == on_steps(nib[idx]) * STEP, "R4 per-digit width", len, on_steps(nib[idx]) * STEP);
        end
    endtask

    task automatic t_blink_planes;
        int idx, len, seg;
        write_digit(1, 1, 0, 8'h3C);
        write_digit(1, 0, 0, 8'h5A);
        do_cfg(0, 1, 1, 0, 0, 1, 0, 0, 15);
        get_window(idx, len, seg);
        check(seg == 8'h5A, "R6 phase 0 shows plane A", seg, 8'h5A);
        check(blink_phase == 0, "R6 phase still 0", int'(blink_phase), 0);
        while (blink_phase == 0) @(negedge clk);
        get_window(idx, len, seg);
        get_window(idx, len, seg);
        check(seg == 8'h3C, "R13 both-plane write reached plane B", seg, 8'h3C);
        check(blink_phase == 1, "R6 phase 1 during capture", int'(blink_phase), 1);
        do_cfg(0, 0, 1, 0, 0, 0, 0, 0, 15);
        get_window(idx, len, seg);
        get_window(idx, len, seg);
        check(seg == 8'h5A, "R5 blink off shows plane A", seg, 8'h5A);
    endtask

    task automatic t_blink_rate;
        int n;
        do_cfg(0, 0, 1, 0, 0, 1, 0, 0, 0);
        check(blink_phase == 0, "R8 restart clears phase", int'(blink_phase), 0);
        n = 0;
        while (blink_phase == 0) begin @(negedge clk); n++; end
        check(n == FAST, "R8 first toggle after restart", n, FAST);
        n = 0;
        while (blink_phase == 1) begin @(negedge clk); n++; end
        check(n == FAST, "R7 fast half period", n, FAST);
        do_cfg(0, 0, 0, 0, 0, 1, 0, 0, 0);
        while (blink_phase == 0) @(negedge clk);
        n = 0;
        while (blink_phase == 1) begin @(negedge clk); n++; end
        check(n == SLOW, "R7 slow half period", n, SLOW);
    endtask

    task automatic t_test_mode;
        int idx, len, seg;
        do_cfg(0, 0, 0, 0, 1, 0, 0, 1, 0);
        get_window(idx, len, seg);
        get_window(idx, len, seg);
        check(seg == 8'hFF, "R10 test all segments", seg, 8'hFF);
        check(len == 15 * STEP, "R10 test full width", len, 15 * STEP);
    endtask

    task automatic t_shutdown;
        int idx, len, seg;
        bit bad = 0;
        logic ph;
        write_digit(1, 0, 0, 8'h81);
        do_cfg(0, 0, 1, 0, 0, 1, 0, 1, 6);
        while (blink_phase == 0) @(negedge clk);
        do_cfg(1, 0, 1, 0, 0, 0, 0, 1, 6);
        ph = blink_phase;
        for (int i = 0; i < FAST + 20; i++) begin
            @(negedge clk);
            if (dig_sel != 0 || seg_on != 0 || blink_phase != ph) bad = 1;
        end
        check(!bad, "R11 shutdown dark and phase held", int'(blink_phase), int'(ph));
        do_cfg(0, 0, 1, 0, 0, 0, 0, 1, 6);
        get_window(idx, len, seg);
        check(idx == 0, "R11 restart at slot 0", idx, 0);
        check(seg == 8'h81, "R11 data retained", seg, 8'h81);
    endtask

    task automatic t_clear;
        int idx, len, seg;
        bit bad = 0;
        write_digit(0, 1, 1, 8'hE7);
        do_cfg(0, 1, 1, 0, 0, 1, 1, 1, 15);
        get_window(idx, len, seg);
        for (int n = 0; n < 16; n++) begin
            get_window(idx, len, seg);
            if (seg != 0) bad = 1;
        end
        check(!bad, "R9 clear empties both planes", seg, 0);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_scan_limit();
        t_global_intensity();
        t_per_digit();
        t_blink_planes();
        t_blink_rate();
        t_test_mode();
        t_shutdown();
        t_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule